// File: doc/BRIEF.md
# Conditioned-Reload Watchdog Timer

This block is a watchdog counter that a processor can only restart through a two-step handshake on a single 8-bit control register. The first write arms the block and sets a 4-bit preset that gives the time to expiry in seconds. The next write sets the load bit and restarts the count. Any other write in between breaks the handshake. A load write that arrives without arming is dropped. This makes a stray single store much less likely to keep a hung processor alive.

The counter is 8 bits wide at the default setting. A reload puts the preset in the upper nibble and clears the lower nibble. The count then steps down by one on each pulse of a slow tick strobe, and the system supplies one tick per sixteenth of a second. The upper nibble therefore reads as whole seconds left. When the count runs out, the block issues a one-cycle reset request. The count then stays at zero until the next valid handshake. The reset pulse width, the tick source and the processor are all outside this block.

Top module: `cond_reload_watchdog`

## Requirements
- R1: After reset the state is as follows. count is 0 and expire is low. rd_data is 0x00 and the block is not armed. The timer is idle, so ticks cause no expiry and leave count at 0 until a valid reload.
- R2: rd_data has a fixed layout. Bit 7 is the arm state and bits 6..3 are the stored preset. Bits 2..1 always read 0. Bit 0, the load bit, always reads 0 because it clears itself once acted on.
- R3: A write with bit 7 = 1 and bit 0 = 0 arms the block. Every other write disarms it. This includes writes with bit 7 = 0 and bit 0 = 0, and every write with bit 0 = 1.
- R4: Only a write with bit 0 = 0 updates the stored preset, which it takes from bits 6..3. On a write with bit 0 = 1, bits 6..3 are ignored.
- R5: A write with bit 0 = 1 while the block is armed is a valid reload. One cycle later count equals the stored preset times 16 (preset in the upper nibble, lower nibble 0), and the countdown is running.
- R6: A write with bit 0 = 1 while the block is not armed leaves count and the running state unchanged.
- R7: While the countdown runs, each cycle with tick high lowers count by exactly 1. Cycles without tick leave count unchanged.
- R8: Take a preset N of 1 or more. The 16·N-th tick after the reload brings count to 0, and expire is high for exactly the one cycle after that tick. With preset 0, the first tick expires.
- R9: After expiry, count stays at 0 and further ticks produce no expire pulse until the next valid reload.
- R10: A valid reload and a tick in the same cycle give count = preset times 16 and no decrement. No expire is raised.
- R11: A valid reload while the countdown runs restarts it from the new preset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe, one cycle per write |
| wr_data | input | 8 | Control register write value |
| tick | input | 1 | One-cycle strobe, one per sixteenth of a second |
| rd_data | output | 8 | Control register read value |
| count | output | 8 | Current watchdog count (upper nibble = seconds) |
| expire | output | 1 | One-cycle reset request on expiry |

## Verification
The assertions assume that each write is a single-cycle wr_en strobe. They also assume that tick is a clean one-cycle pulse that may coincide with a write. The reload checks read the arm state and preset back from rd_data rather than from internal signals, so they need rd_data to be a faithful view of the register. The bench drives every input on the falling edge and holds each write for exactly one cycle. Ticks come with idle cycles between them, except in the one case where a tick is deliberately placed in the same cycle as the load write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int REG_W      = 8;
    localparam int PRESET_W   = 4;

    typedef struct packed {
        logic                arm;
        logic [PRESET_W-1:0] preset;
        logic [1:0]          spare;
        logic                load;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_ARM,
        WR_OTHER,
        WR_LOAD
    } wr_kind_e;

    function automatic wr_kind_e classify_write(input logic en, input ctrl_word_t w);
        if (!en)
            return WR_NONE;
        else if (w.load)
            return WR_LOAD;
        else if (w.arm)
            return WR_ARM;
        else
            return WR_OTHER;
    endfunction

    function automatic ctrl_word_t pack_readback(input logic armed,
                                                 input logic [PRESET_W-1:0] preset);
        ctrl_word_t r;
        r.arm    = armed;
        r.preset = preset;
        r.spare  = 2'b00;
        r.load   = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic                reload,
    output logic [PRESET_W-1:0] preset,
    output logic [REG_W-1:0]    rd_data
);

    ctrl_word_t          wr_word;
    wr_kind_e            kind;
    logic                armed_q;
    logic [PRESET_W-1:0] preset_q;

    assign wr_word = ctrl_word_t'(wr_data);
    assign kind    = classify_write(wr_en, wr_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            preset_q <= '0;
        end else begin
            unique case (kind)
                WR_ARM: begin
                    armed_q  <= 1'b1;
                    preset_q <= wr_word.preset;
                end
                WR_OTHER: begin
                    armed_q  <= 1'b0;
                    preset_q <= wr_word.preset;
                end
                WR_LOAD: begin
                    armed_q  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign reload  = (kind == WR_LOAD) && armed_q;
    assign preset  = preset_q;
    assign rd_data = REG_W'(pack_readback(armed_q, preset_q));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int FRAC_W = 4,
    localparam int CNT_W = PRESET_W + FRAC_W
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                reload,
    input  logic [PRESET_W-1:0] preset,
    input  logic                tick,
    output logic [CNT_W-1:0]    count,
    output logic                expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             running_q;
    logic             expire_q;
    logic             last_step;

    assign last_step = (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
            expire_q  <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (reload) begin
                cnt_q     <= {preset, {FRAC_W{1'b0}}};
                running_q <= 1'b1;
            end else if (tick && running_q) begin
                if (last_step) begin
                    cnt_q     <= '0;
                    running_q <= 1'b0;
                    expire_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign count  = cnt_q;
    assign expire = expire_q;

endmodule

// File: rtl/cond_reload_watchdog.sv
module cond_reload_watchdog
    import wdg_pkg::*;
#(
    parameter int FRAC_W = 4,
    localparam int CNT_W = PRESET_W + FRAC_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tick,
    output logic [REG_W-1:0] rd_data,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic                reload;
    logic [PRESET_W-1:0] preset;

    wdg_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .reload  (reload),
        .preset  (preset),
        .rd_data (rd_data)
    );

    wdg_counter #(.FRAC_W(FRAC_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .reload (reload),
        .preset (preset),
        .tick   (tick),
        .count  (count),
        .expire (expire)
    );

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int FRAC_W = 4,
    localparam int CNT_W = PRESET_W + FRAC_W
)(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             tick,
    input logic [REG_W-1:0] rd_data,
    input logic [CNT_W-1:0] count,
    input logic             expire
);

    assert_arm_update_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[7] == $past(wr_data[7] && !wr_data[0]));

    assert_preset_kept_on_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[0]) |=> rd_data[6:3] == $past(rd_data[6:3]));

    assert_valid_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[0] && rd_data[7])
            |=> count == {$past(rd_data[6:3]), {FRAC_W{1'b0}}});

    assert_lone_load_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[0] && !rd_data[7] && !tick) |=> $stable(count));

    assert_no_count_rise_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_data[0] && rd_data[7]) |=> count <= $past(count));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    assert_expire_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
        expire |-> count == '0);

endmodule

bind cond_reload_watchdog wdg_checker #(.FRAC_W(FRAC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick    (tick),
    .rd_data (rd_data),
    .count   (count),
    .expire  (expire)
);

// File: tb/cond_reload_watchdog_test.sv
module cond_reload_watchdog_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       tick;
    logic [7:0] rd_data;
    logic [7:0] count;
    logic       expire;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4ns clk = ~clk;

    cond_reload_watchdog uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tick    (tick),
        .rd_data (rd_data),
        .count   (count),
        .expire  (expire)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic reload_with(input int n);
        do_write(8'h80 | 8'(n << 3));
        do_write(8'h01);
    endtask

    initial begin
        #800us;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=completed");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       m_armed;
        logic [3:0] m_preset;
        int         m_cnt;
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        check(count == 8'h00, "R1 count", count, 0);
        check(expire == 1'b0, "R1 expire", expire, 0);
        for (int i = 0; i < 3; i++) begin
            do_tick();
            check(expire == 1'b0 && count == 0, "R1 idle tick", {expire, count}, 0);
        end

        // R2 R3 R4 R5 R6: sweep every write value with a register model
        m_armed = 1'b0; m_preset = 4'h0; m_cnt = 0;
        for (int v = 0; v < 256; v++) begin
            do_write(8'(v));
            if (v[0]) begin
                if (m_armed) m_cnt = int'(m_preset) * 16;
                m_armed = 1'b0;
            end else begin
                m_armed  = v[7];
                m_preset = 4'(v >> 3);
            end
            check(rd_data == {m_armed, m_preset, 3'b000}, "R2 R3 R4 readback",
                  rd_data, {m_armed, m_preset, 3'b000});
            check(int'(count) == m_cnt, "R5 R6 count after write", count, m_cnt);
        end

        // R5 R7 R8 R9: every preset counted down to expiry
        for (int n = 0; n < 16; n++) begin
            int lim;
            lim = (n == 0) ? 1 : n * 16;
            reload_with(n);
            check(int'(count) == n * 16, "R5 reload value", count, n * 16);
            for (int k = 1; k <= lim; k++) begin
                do_tick();
                check(expire == (k == lim), "R8 expire timing", expire, int'(k == lim));
                check(int'(count) == ((n == 0) ? 0 : lim - k), "R7 decrement",
                      count, (n == 0) ? 0 : lim - k);
            end
            @(negedge clk);
            check(expire == 1'b0, "R8 single-cycle pulse", expire, 0);
            do_tick();
            check(expire == 1'b0 && count == 0, "R9 hold after expiry", {expire, count}, 0);
        end

        // R7 no tick, no change
        reload_with(3);
        for (int i = 0; i < 5; i++) do_tick();
        check(count == 8'd43, "R7 after five ticks", count, 43);
        repeat (6) @(negedge clk);
        check(count == 8'd43, "R7 idle cycles", count, 43);

        // R6 lone load ignored
        do_write(8'h01);
        check(count == 8'd43, "R6 lone load count", count, 43);
        check(rd_data == 8'h18, "R6 lone load readback", rd_data, 8'h18);
        do_tick();
        check(count == 8'd42, "R6 still running", count, 42);

        // R3 an intervening write breaks the handshake
        do_write(8'h90);
        check(rd_data == 8'h90, "R3 armed", rd_data, 8'h90);
        do_write(8'h18);
        check(rd_data == 8'h18, "R3 disarmed", rd_data, 8'h18);
        do_write(8'h01);
        check(count == 8'd42, "R3 broken sequence", count, 42);

        // R4 preset bits of a load write ignored
        do_write(8'h88);
        do_write(8'h79);
        check(count == 8'd16, "R4 load uses stored preset", count, 16);
        check(rd_data == 8'h08, "R4 preset kept", rd_data, 8'h08);

        // R10 reload and tick in the same cycle
        do_write(8'h90);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h01; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; tick = 1'b0;
        check(count == 8'd32, "R10 reload wins", count, 32);
        check(expire == 1'b0, "R10 no expire", expire, 0);

        // R11 restart while running
        for (int i = 0; i < 10; i++) do_tick();
        check(count == 8'd22, "R11 before restart", count, 22);
        reload_with(1);
        check(count == 8'd16, "R11 restarted", count, 16);
        for (int k = 1; k <= 16; k++) begin
            do_tick();
            check(expire == (k == 16), "R11 expiry after restart", expire, int'(k == 16));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule